// File: doc/BRIEF.md
# Multi-ID Translation Lookup with Address-Space Check

This block translates an effective address into a real address by scanning a small set of software-written translation entries. Each entry holds a valid bit, an owner ID (zero meaning "any owner"), an effective page number, a page-size code, a real page number, one address-space bit and an eight-bit protection byte. A request carries the effective address, the access kind, the privilege state, the instruction and data relocation bits, up to three owner IDs and a flag telling whether the second and third IDs exist. The response returns the real address (up to 36 bits), the permission nibble that applied and a result code.

All entries are compared in parallel in a single cycle and the lowest-numbered entry that is not a miss decides the result; the response is registered. Requests enter through a valid/ready port and responses leave through a valid/ready port. The block holds one response: while `rsp_valid` is high and `rsp_ready` is low, the response stays unchanged and no new request is taken (`req_ready` = `!rsp_valid || rsp_ready`). Entries are loaded through a plain write port.

Top module: `tlbchk`

## Requirements
- R1: After reset `rsp_valid` is 0 and `req_ready` is 1.
- R2: An entry's owner check passes when its owner ID is 0, equals `pid0`, or, only when `extra_pids` is 1, equals a nonzero `pid1` or a nonzero `pid2`.
- R3: Size code s gives a page of 1 KiB shifted left by 2*s; an entry matches when the effective address with the in-page bits cleared equals its stored page number, and real address bits below 32 are the real page number with the in-page bits cleared, ORed with the in-page bits of the effective address.
- R4: With `extra_pids` 0, real address bits 35:32 carry bits 3:0 of the real page number; with `extra_pids` 1 they are 0.
- R5: The required address space is `req_ir` for a fetch and `req_dr` for a load or store; an entry whose space bit differs counts as a miss.
- R6: In user state (`req_pr`=1) the permission nibble is protection bits 3:0; in supervisor state it is bits 7:4.
- R7: Access kinds are 0 load, 1 store, 2 fetch, needing nibble bit 0 (read), bit 1 (write) and bit 2 (execute) respectively; result codes are 0 granted, 1 miss, 2 data denied, 3 execute denied, where a permission failure gives 3 for a fetch and 2 otherwise.
- R8: The lowest-indexed entry that is not a miss sets the result, even when it denies the access; higher entries are then ignored.
- R9: On a miss the real address and permission outputs are 0.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0 the response holds and `req_ready` is 0.
- R11: An entry write takes effect for requests accepted after the clock edge that performs the write; a request accepted on that same edge sees the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Entry written |
| wr_vld | input | 1 | Entry valid bit |
| wr_pid | input | PID_W | Entry owner ID (0 = any) |
| wr_epn | input | EA_W | Entry effective page number (page-aligned) |
| wr_size | input | SZ_W | Page-size code |
| wr_rpn | input | EA_W | Real page number |
| wr_as | input | 1 | Entry address-space bit |
| wr_prot | input | 8 | Protection: 7:4 supervisor, 3:0 user |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_ea | input | EA_W | Effective address |
| req_acc | input | 2 | Access kind |
| req_pr | input | 1 | User state |
| req_ir | input | 1 | Instruction relocation space |
| req_dr | input | 1 | Data relocation space |
| pid0 | input | PID_W | Primary owner ID |
| pid1 | input | PID_W | Second owner ID |
| pid2 | input | PID_W | Third owner ID |
| extra_pids | input | 1 | Second and third IDs exist |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_raddr | output | EA_W+4 | Real address |
| rsp_perm | output | 4 | Permission nibble applied |
| rsp_code | output | 2 | Result code |

## Verification
The hardest case to reach is an entry that matches the address and an owner ID but denies the access while a later entry would grant it, since only the first non-miss may decide. The bench places two entries on the same 1 KiB page with different owner IDs and permissions and sweeps every combination of ID set, extra-ID flag, privilege, relocation bits and access kind against a list of addresses inside, at the edges of and outside each page, so the denying-first-entry case arises alongside wildcard, second-ID and address-space-mismatch hits.

// File: rtl/tlbchk_pkg.sv
package tlbchk_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_MISS  = 2'd1,
    RES_DDENY = 2'd2,
    RES_XDENY = 2'd3
  } res_e;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;
  localparam int BASE_PAGE_LOG2 = 10;
  localparam int EXT_BITS = 4;
endpackage

// File: rtl/tlbchk_store.sv
module tlbchk_store #(
  parameter int ENTRIES = 4,
  parameter int EA_W    = 32,
  parameter int PID_W   = 8,
  parameter int SZ_W    = 3,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_vld,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [EA_W-1:0]  wr_epn,
  input  logic [SZ_W-1:0]  wr_size,
  input  logic [EA_W-1:0]  wr_rpn,
  input  logic             wr_as,
  input  logic [7:0]       wr_prot,
  output logic             ent_vld  [ENTRIES],
  output logic [PID_W-1:0] ent_pid  [ENTRIES],
  output logic [EA_W-1:0]  ent_epn  [ENTRIES],
  output logic [SZ_W-1:0]  ent_size [ENTRIES],
  output logic [EA_W-1:0]  ent_rpn  [ENTRIES],
  output logic             ent_as   [ENTRIES],
  output logic [7:0]       ent_prot [ENTRIES]
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_vld[g]  <= 1'b0;
        ent_pid[g]  <= '0;
        ent_epn[g]  <= '0;
        ent_size[g] <= '0;
        ent_rpn[g]  <= '0;
        ent_as[g]   <= 1'b0;
        ent_prot[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        ent_vld[g]  <= wr_vld;
        ent_pid[g]  <= wr_pid;
        ent_epn[g]  <= wr_epn;
        ent_size[g] <= wr_size;
        ent_rpn[g]  <= wr_rpn;
        ent_as[g]   <= wr_as;
        ent_prot[g] <= wr_prot;
      end
    end
  end
endmodule

// File: rtl/tlbchk_cmp.sv
module tlbchk_cmp
  import tlbchk_pkg::*;
#(
  parameter int EA_W  = 32,
  parameter int PID_W = 8,
  parameter int SZ_W  = 3,
  localparam int RA_W = EA_W + EXT_BITS
) (
  input  logic [EA_W-1:0]  ea,
  input  logic [PID_W-1:0] pid0,
  input  logic [PID_W-1:0] pid1,
  input  logic [PID_W-1:0] pid2,
  input  logic             extra_pids,
  input  logic             as_req,
  input  logic             e_vld,
  input  logic [PID_W-1:0] e_pid,
  input  logic [EA_W-1:0]  e_epn,
  input  logic [SZ_W-1:0]  e_size,
  input  logic [EA_W-1:0]  e_rpn,
  input  logic             e_as,
  output logic             hit,
  output logic [RA_W-1:0]  raddr
);
  logic [EA_W-1:0] mask;
  logic            pid_ok;
  logic            page_ok;
  logic [EXT_BITS-1:0] ext;

  always_comb begin
    mask    = {EA_W{1'b1}} << (BASE_PAGE_LOG2 + 2 * int'(e_size));
    page_ok = ((ea & mask) == e_epn);
    pid_ok  = (e_pid == '0) || (e_pid == pid0);
    if (extra_pids) begin
      if ((pid1 != '0) && (e_pid == pid1)) pid_ok = 1'b1;
      if ((pid2 != '0) && (e_pid == pid2)) pid_ok = 1'b1;
    end
    hit   = e_vld && page_ok && pid_ok && (as_req == e_as);
    ext   = extra_pids ? '0 : e_rpn[EXT_BITS-1:0];
    raddr = {ext, (e_rpn & mask) | (ea & ~mask)};
  end
endmodule

// File: rtl/tlbchk_pick.sv
module tlbchk_pick
  import tlbchk_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int RA_W    = 36
) (
  input  logic            hit   [ENTRIES],
  input  logic [RA_W-1:0] raddr [ENTRIES],
  input  logic [7:0]      prot  [ENTRIES],
  input  logic            pr,
  input  logic [1:0]      acc,
  output logic [1:0]      code,
  output logic [RA_W-1:0] sel_raddr,
  output logic [3:0]      perm
);
  logic       found;
  logic [7:0] sel_prot;
  logic       allowed;

  always_comb begin
    found     = 1'b0;
    sel_raddr = '0;
    sel_prot  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found     = 1'b1;
        sel_raddr = raddr[i];
        sel_prot  = prot[i];
      end
    end
    perm = pr ? sel_prot[3:0] : sel_prot[7:4];
    unique case (acc)
      ACC_LOAD:  allowed = perm[PERM_R];
      ACC_STORE: allowed = perm[PERM_W];
      ACC_FETCH: allowed = perm[PERM_X];
      default:   allowed = 1'b0;
    endcase
    if (!found) begin
      code = RES_MISS;
      perm = '0;
    end else if (allowed) begin
      code = RES_OK;
    end else if (acc == ACC_FETCH) begin
      code = RES_XDENY;
    end else begin
      code = RES_DDENY;
    end
  end
endmodule

// File: rtl/tlbchk.sv
module tlbchk
  import tlbchk_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int EA_W    = 32,
  parameter int PID_W   = 8,
  parameter int SZ_W    = 3,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int RA_W   = EA_W + EXT_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_vld,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [EA_W-1:0]  wr_epn,
  input  logic [SZ_W-1:0]  wr_size,
  input  logic [EA_W-1:0]  wr_rpn,
  input  logic             wr_as,
  input  logic [7:0]       wr_prot,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [EA_W-1:0]  req_ea,
  input  logic [1:0]       req_acc,
  input  logic             req_pr,
  input  logic             req_ir,
  input  logic             req_dr,
  input  logic [PID_W-1:0] pid0,
  input  logic [PID_W-1:0] pid1,
  input  logic [PID_W-1:0] pid2,
  input  logic             extra_pids,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [RA_W-1:0]  rsp_raddr,
  output logic [3:0]       rsp_perm,
  output logic [1:0]       rsp_code
);
  logic             ent_vld  [ENTRIES];
  logic [PID_W-1:0] ent_pid  [ENTRIES];
  logic [EA_W-1:0]  ent_epn  [ENTRIES];
  logic [SZ_W-1:0]  ent_size [ENTRIES];
  logic [EA_W-1:0]  ent_rpn  [ENTRIES];
  logic             ent_as   [ENTRIES];
  logic [7:0]       ent_prot [ENTRIES];

  logic             hit      [ENTRIES];
  logic [RA_W-1:0]  ent_ra   [ENTRIES];
  logic             as_req;
  logic [1:0]       nx_code;
  logic [RA_W-1:0]  nx_raddr;
  logic [3:0]       nx_perm;
  logic             accept;

  tlbchk_store #(
    .ENTRIES(ENTRIES), .EA_W(EA_W), .PID_W(PID_W), .SZ_W(SZ_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vld(wr_vld), .wr_pid(wr_pid),
    .wr_epn(wr_epn), .wr_size(wr_size), .wr_rpn(wr_rpn), .wr_as(wr_as),
    .wr_prot(wr_prot),
    .ent_vld(ent_vld), .ent_pid(ent_pid), .ent_epn(ent_epn),
    .ent_size(ent_size), .ent_rpn(ent_rpn), .ent_as(ent_as),
    .ent_prot(ent_prot)
  );

  assign as_req = (req_acc == ACC_FETCH) ? req_ir : req_dr;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    tlbchk_cmp #(.EA_W(EA_W), .PID_W(PID_W), .SZ_W(SZ_W)) u_cmp (
      .ea(req_ea), .pid0(pid0), .pid1(pid1), .pid2(pid2),
      .extra_pids(extra_pids), .as_req(as_req),
      .e_vld(ent_vld[g]), .e_pid(ent_pid[g]), .e_epn(ent_epn[g]),
      .e_size(ent_size[g]), .e_rpn(ent_rpn[g]), .e_as(ent_as[g]),
      .hit(hit[g]), .raddr(ent_ra[g])
    );
  end

  tlbchk_pick #(.ENTRIES(ENTRIES), .RA_W(RA_W)) u_pick (
    .hit(hit), .raddr(ent_ra), .prot(ent_prot), .pr(req_pr), .acc(req_acc),
    .code(nx_code), .sel_raddr(nx_raddr), .perm(nx_perm)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_raddr <= '0;
      rsp_perm  <= '0;
      rsp_code  <= RES_MISS;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_raddr <= nx_raddr;
      rsp_perm  <= nx_perm;
      rsp_code  <= nx_code;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tlbchk_sva.sv
module tlbchk_sva #(
  parameter int RA_W = 36
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [RA_W-1:0] rsp_raddr,
  input logic [3:0]      rsp_perm,
  input logic [1:0]      rsp_code
);
  // R10: a stalled response holds its contents
  p_hold_when_stalled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_raddr)
                                   && $stable(rsp_perm) && $stable(rsp_code)));

  // R10: no request taken while the held response is stalled
  p_no_take_when_stalled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R1: a response only appears after an accepted request
  p_rsp_has_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready));

  // R9: miss responses carry zero address and permissions
  p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'd1) |-> (rsp_raddr == '0 && rsp_perm == 4'd0));

  // R7: execute denial means the execute bit was clear
  p_xdeny_no_x_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'd3) |-> !rsp_perm[2]);

  // R7: a grant always comes with some permission
  p_grant_has_perm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'd0) |-> (rsp_perm != 4'd0));
endmodule

bind tlbchk tlbchk_sva #(.RA_W(RA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_raddr(rsp_raddr),
  .rsp_perm(rsp_perm), .rsp_code(rsp_code)
);

// File: tb/tlbchk_tb.sv
module tlbchk_tb;
  localparam int ENTRIES = 4;
  localparam int EA_W = 32;
  localparam int PID_W = 8;
  localparam int SZ_W = 3;
  localparam int RA_W = EA_W + 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n;
  logic             wr_en;
  logic [1:0]       wr_idx;
  logic             wr_vld;
  logic [PID_W-1:0] wr_pid;
  logic [EA_W-1:0]  wr_epn;
  logic [SZ_W-1:0]  wr_size;
  logic [EA_W-1:0]  wr_rpn;
  logic             wr_as;
  logic [7:0]       wr_prot;
  logic             req_valid;
  logic             req_ready;
  logic [EA_W-1:0]  req_ea;
  logic [1:0]       req_acc;
  logic             req_pr, req_ir, req_dr;
  logic [PID_W-1:0] pid0, pid1, pid2;
  logic             extra_pids;
  logic             rsp_valid;
  logic             rsp_ready;
  logic [RA_W-1:0]  rsp_raddr;
  logic [3:0]       rsp_perm;
  logic [1:0]       rsp_code;

  tlbchk #(.ENTRIES(ENTRIES), .EA_W(EA_W), .PID_W(PID_W), .SZ_W(SZ_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vld(wr_vld),
    .wr_pid(wr_pid), .wr_epn(wr_epn), .wr_size(wr_size), .wr_rpn(wr_rpn),
    .wr_as(wr_as), .wr_prot(wr_prot), .req_valid(req_valid),
    .req_ready(req_ready), .req_ea(req_ea), .req_acc(req_acc), .req_pr(req_pr),
    .req_ir(req_ir), .req_dr(req_dr), .pid0(pid0), .pid1(pid1), .pid2(pid2),
    .extra_pids(extra_pids), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_raddr(rsp_raddr), .rsp_perm(rsp_perm), .rsp_code(rsp_code)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench copy of the entries it wrote
  logic             m_vld  [ENTRIES];
  logic [PID_W-1:0] m_pid  [ENTRIES];
  logic [EA_W-1:0]  m_epn  [ENTRIES];
  logic [SZ_W-1:0]  m_size [ENTRIES];
  logic [EA_W-1:0]  m_rpn  [ENTRIES];
  logic             m_as   [ENTRIES];
  logic [7:0]       m_prot [ENTRIES];

  logic [RA_W-1:0] e_ra;
  logic [3:0]      e_perm;
  logic [1:0]      e_code;

  task automatic chk(input string tag, input bit ok, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [EA_W-1:0] ea, input logic [1:0] acc,
                       input bit pr, input bit ir, input bit dr,
                       input logic [PID_W-1:0] p0, input logic [PID_W-1:0] p1,
                       input logic [PID_W-1:0] p2, input bit ex);
    e_ra = '0; e_perm = '0; e_code = 2'd1;
    for (int i = 0; i < ENTRIES; i++) begin
      logic [EA_W-1:0] pg;
      bit pok, asr;
      pg = (EA_W'(1) << (10 + 2 * int'(m_size[i]))) - 1;
      if (!m_vld[i]) continue;
      if ((ea & ~pg) != m_epn[i]) continue;
      pok = (m_pid[i] == 0) || (m_pid[i] == p0)
         || (ex && p1 != 0 && m_pid[i] == p1) || (ex && p2 != 0 && m_pid[i] == p2);
      if (!pok) continue;
      asr = (acc == 2'd2) ? ir : dr;
      if (asr != m_as[i]) continue;
      e_ra   = {(ex ? 4'h0 : m_rpn[i][3:0]), (m_rpn[i] & ~pg) | (ea & pg)};
      e_perm = pr ? m_prot[i][3:0] : m_prot[i][7:4];
      if (e_perm[acc]) e_code = 2'd0;
      else e_code = (acc == 2'd2) ? 2'd3 : 2'd2;
      break;
    end
  endtask

  task automatic wr(input int idx, input bit v, input logic [PID_W-1:0] p,
                    input logic [EA_W-1:0] epn, input logic [SZ_W-1:0] sz,
                    input logic [EA_W-1:0] rpn, input bit as, input logic [7:0] pt);
    wr_en = 1; wr_idx = 2'(idx); wr_vld = v; wr_pid = p; wr_epn = epn;
    wr_size = sz; wr_rpn = rpn; wr_as = as; wr_prot = pt;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
    m_vld[idx] = v; m_pid[idx] = p; m_epn[idx] = epn; m_size[idx] = sz;
    m_rpn[idx] = rpn; m_as[idx] = as; m_prot[idx] = pt;
  endtask

  task automatic drive(input logic [EA_W-1:0] ea, input logic [1:0] acc,
                       input bit pr, input bit ir, input bit dr,
                       input logic [PID_W-1:0] p0, input logic [PID_W-1:0] p1,
                       input logic [PID_W-1:0] p2, input bit ex);
    req_ea = ea; req_acc = acc; req_pr = pr; req_ir = ir; req_dr = dr;
    pid0 = p0; pid1 = p1; pid2 = p2; extra_pids = ex;
  endtask

  task automatic req(input string tag, input logic [EA_W-1:0] ea,
                     input logic [1:0] acc, input bit pr, input bit ir,
                     input bit dr, input logic [PID_W-1:0] p0,
                     input logic [PID_W-1:0] p1, input logic [PID_W-1:0] p2,
                     input bit ex);
    drive(ea, acc, pr, ir, dr, p0, p1, p2, ex);
    req_valid = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    model(ea, acc, pr, ir, dr, p0, p1, p2, ex);
    chk(tag, rsp_valid && rsp_code == e_code && rsp_raddr == e_ra
        && rsp_perm == e_perm,
        {21'd0, rsp_valid, rsp_code, rsp_perm, rsp_raddr},
        {21'd1, 1'b1, e_code, e_perm, e_ra});
  endtask

  function automatic string tag_of(input logic [1:0] c);
    case (c)
      2'd0: return "R3_R6_sweep_grant";
      2'd1: return "R9_sweep_miss";
      2'd2: return "R7_sweep_data_deny";
      default: return "R7_R8_sweep_exec_deny";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [EA_W-1:0] eas [6];
    logic [PID_W-1:0] ps [4][3];
    rst_n = 0; wr_en = 0; wr_idx = 0; wr_vld = 0; wr_pid = 0; wr_epn = 0;
    wr_size = 0; wr_rpn = 0; wr_as = 0; wr_prot = 0; req_valid = 0;
    rsp_ready = 1;
    drive('0, 2'd0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < ENTRIES; i++) begin
      m_vld[i] = 0; m_pid[i] = 0; m_epn[i] = 0; m_size[i] = 0;
      m_rpn[i] = 0; m_as[i] = 0; m_prot[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1_reset", !rsp_valid && req_ready, {62'd0, rsp_valid, req_ready}, 64'd1);

    // entries: user nibble bits 3:0, supervisor 7:4; bit0 R, bit1 W, bit2 X
    wr(0, 1, 8'd5, 32'h0000_1000, 3'd1, 32'h1234_5003, 0, 8'h71);
    wr(1, 1, 8'd0, 32'h0010_0000, 3'd2, 32'h8000_0000, 1, 8'h35);
    wr(2, 1, 8'd9, 32'h0020_0000, 3'd0, 32'h0000_4C0A, 0, 8'h62);
    wr(3, 1, 8'd7, 32'h0020_0000, 3'd0, 32'h0000_7C05, 0, 8'h77);

    req("R4_ext_bits_no_extra", 32'h0000_1ABC, 2'd0, 0, 0, 0, 8'd5, 0, 0, 0);
    chk("R4_upper_nibble", rsp_raddr[35:32] == 4'h3, 64'(rsp_raddr[35:32]), 64'h3);
    req("R4_ext_bits_extra", 32'h0000_1ABC, 2'd0, 0, 0, 0, 8'd5, 0, 0, 1);
    chk("R4_upper_zero", rsp_raddr[35:32] == 4'h0, 64'(rsp_raddr[35:32]), 64'h0);
    req("R2_pid1_hit", 32'h0020_0123, 2'd1, 1, 0, 0, 8'd1, 8'd9, 0, 1);
    chk("R2_pid1_grant", rsp_code == 2'd0, 64'(rsp_code), 64'd0);
    req("R2_pid1_ignored_without_extra", 32'h0020_0123, 2'd1, 1, 0, 0, 8'd1, 8'd9, 0, 0);
    chk("R2_miss", rsp_code == 2'd1, 64'(rsp_code), 64'd1);
    req("R8_first_denies", 32'h0020_0123, 2'd0, 1, 0, 0, 8'd9, 8'd7, 0, 1);
    chk("R8_data_deny", rsp_code == 2'd2, 64'(rsp_code), 64'd2);
    req("R5_as_mismatch", 32'h0000_1ABC, 2'd0, 0, 0, 1, 8'd5, 0, 0, 0);
    chk("R5_miss", rsp_code == 2'd1 && rsp_raddr == 0, 64'(rsp_code), 64'd1);
    req("R6_user_nibble", 32'h0010_2000, 2'd2, 1, 1, 0, 8'd3, 0, 0, 0);
    chk("R6_user_exec", rsp_code == 2'd0 && rsp_perm == 4'h5, 64'(rsp_perm), 64'h5);
    req("R7_sup_exec_deny", 32'h0010_2000, 2'd2, 0, 1, 0, 8'd3, 0, 0, 0);
    chk("R7_code3", rsp_code == 2'd3, 64'(rsp_code), 64'd3);

    // R11: write and request on the same edge
    wr_en = 1; wr_idx = 0; wr_vld = 0; wr_pid = 5; wr_epn = 32'h0000_1000;
    wr_size = 1; wr_rpn = 32'h1234_5003; wr_as = 0; wr_prot = 8'h71;
    drive(32'h0000_1ABC, 2'd0, 0, 0, 0, 8'd5, 0, 0, 0);
    req_valid = 1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    chk("R11_same_edge_old", rsp_valid && rsp_code == 2'd0, 64'(rsp_code), 64'd0);
    m_vld[0] = 0;
    req("R11_after_write_miss", 32'h0000_1ABC, 2'd0, 0, 0, 0, 8'd5, 0, 0, 0);
    chk("R11_miss", rsp_code == 2'd1, 64'(rsp_code), 64'd1);
    wr(0, 1, 8'd5, 32'h0000_1000, 3'd1, 32'h1234_5003, 0, 8'h71);

    // R10: back-pressure
    @(negedge clk);
    rsp_ready = 0;
    drive(32'h0000_1ABC, 2'd0, 0, 0, 0, 8'd5, 0, 0, 0);
    req_valid = 1;
    @(posedge clk);
    @(negedge clk);
    drive(32'h0000_0FFF, 2'd0, 0, 0, 0, 8'd5, 0, 0, 0);
    chk("R10_not_ready", !req_ready, 64'(req_ready), 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R10_held", rsp_valid && rsp_code == 2'd0 && rsp_raddr == 36'h3_1234_5ABC,
        64'(rsp_raddr), 64'h3_1234_5ABC);
    rsp_ready = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk("R10_next_taken", rsp_valid && rsp_code == 2'd1, 64'(rsp_code), 64'd1);

    // sweep
    eas[0] = 32'h0000_1123; eas[1] = 32'h0000_1FFF; eas[2] = 32'h0010_3ABC;
    eas[3] = 32'h0020_03FF; eas[4] = 32'h0020_0400; eas[5] = 32'h0000_0FFF;
    ps[0] = '{8'd5, 8'd0, 8'd0}; ps[1] = '{8'd1, 8'd9, 8'd7};
    ps[2] = '{8'd9, 8'd7, 8'd0}; ps[3] = '{8'd0, 8'd0, 8'd7};
    for (int a = 0; a < 6; a++)
      for (int p = 0; p < 4; p++)
        for (int k = 0; k < 3; k++)
          for (int m = 0; m < 16; m++) begin
            model(eas[a], 2'(k), m[0], m[1], m[2], ps[p][0], ps[p][1], ps[p][2], m[3]);
            req(tag_of(e_code), eas[a], 2'(k), m[0], m[1], m[2],
                ps[p][0], ps[p][1], ps[p][2], m[3]);
          end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule